// File: doc/BRIEF.md
# I2C Multi-Master Bus Controller

This block is a single-command I2C master engine for a bus shared with other masters. A host hands it one operation at a time: open a transfer (START), re-open it (repeated START), shift a byte out, shift a byte in, send an acknowledge bit after a received byte, or close the transfer (STOP). The engine drives the open-drain SCL and SDA wires through active-high pull-down enables and samples both wires back through two-stage synchronizers.

Every bit takes four quarter-periods, each lasting `qdiv+1` clock cycles. SDA moves only while SCL is held low, except for the deliberate edges of START and STOP. SDA is sampled at the end of the second SCL-high quarter. A bus monitor watches the synchronized wires for START and STOP conditions from any master. It keeps two flags that tell whether the bus is free, and it can raise an event pulse when the bus is released. Whenever the engine leaves SDA released, it compares the wire against that intended level. A mismatch means another master has won the bus.

Commands are never queued. A command that arrives while one is running is dropped and sets a sticky write-collision flag.

Top module: `i2c_arb_master`

## Requirements
- R1: `cmd_op` encodes 0=START, 1=repeated START, 2=WRITE, 3=READ, 4=ACK, 5=STOP. Codes 6 and 7 are ignored, which means no `done` and no bus activity. `busy` is high while an accepted command runs, and `done` pulses for one cycle, with `busy` low, when the command ends.
- R2: A `cmd_valid` that arrives while `busy` is high is discarded. It has no effect on the running transfer, and it sets `wcol`, which stays set until `clr_flags`.
- R3: The engine checks SDA in five places: during START and repeated START (SDA must read high in the second quarter, while SCL is released), in every WRITE data bit, in the ACK bit, and during STOP (last quarter). If the engine releases SDA and the sampled SDA is low, it releases both wires, ends the command with `done`, and sets `bcol` until `clr_flags`.
- R4: WRITE sends `tx_data` MSB first over 8 clocks. A ninth clock follows with SDA released, and the SDA level sampled there is stored in `rx_ack` (0 means the byte was acknowledged).
- R5: A falling SDA while SCL is high sets `start_seen` and clears `stop_seen`. A rising SDA while SCL is high sets `stop_seen` and clears `start_seen`. The two flags are never high together.
- R6: START is accepted only when `stop_seen` is set or both flags are clear. When `start_seen`=1 and `stop_seen`=0, a START is refused: `done` pulses, `bcol` is set, and both wires stay released.
- R7: When `irq_en` is high, detecting a STOP while `start_seen` is set produces a one-cycle `irq` pulse. When `irq_en` is low, no pulse is produced.
- R8: The engine is active only when both `en` and `master_sel` are high. Otherwise both wires are released, both bus flags are clear, and commands are ignored.
- R9: READ runs 8 clocks with SDA released, shifts the sampled bits MSB first into `rx_data`, and never reports a collision.
- R10: ACK runs one clock and drives the `ack_val` level that was captured with the command (0 pulls SDA low, 1 leaves SDA released).
- R11: One bit period (from SCL rising edge to the next SCL rising edge) is `4*(qdiv+1)` clock cycles, for `qdiv` of 3 or more.
- R12: After reset, both wires are released and `busy`, `wcol`, `bcol`, `start_seen` and `stop_seen` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Module enable |
| master_sel | input | 1 | Master mode select |
| irq_en | input | 1 | Enable for the bus-free event pulse |
| qdiv | input | DIVW | Quarter-period length minus one |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| tx_data | input | 8 | Byte for WRITE |
| ack_val | input | 1 | Bit level for ACK |
| clr_flags | input | 1 | Clears `wcol` and `bcol` |
| scl_in | input | 1 | SCL wire level |
| sda_in | input | 1 | SDA wire level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished pulse |
| rx_data | output | 8 | Byte received by READ |
| rx_ack | output | 1 | Acknowledge level seen after WRITE |
| wcol | output | 1 | Write-collision flag |
| bcol | output | 1 | Bus-collision / refused-claim flag |
| start_seen | output | 1 | START observed on bus |
| stop_seen | output | 1 | STOP observed on bus |
| irq | output | 1 | Bus-released event pulse |

## Verification
Byte transfers are driven with random data, random acknowledge responses and random quarter lengths. The bench captures the wire at each SCL rise, which separates MSB-first ordering, the ninth-bit sampling and the bit period from plain register loading. A second master is imitated in two ways. In the first, it takes the bus with its own START, which separates a refused claim from a normal START. In the second, it pulls SDA low during a data bit and during a START, which separates the arbitration checks in each phase from the receive bits, where a low SDA is legitimate. Back-to-back commands, unused codes and a disabled module show that input is discarded where the requirements say it is.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_RSTART = 3'd1,
        OP_WRITE  = 3'd2,
        OP_READ   = 3'd3,
        OP_ACK    = 3'd4,
        OP_STOP   = 3'd5
    } op_e;

    // Intended wire levels for one quarter, plus whether SDA is compared there.
    typedef struct packed {
        logic scl_rel;
        logic sda_rel;
        logic chk;
    } drive_t;

    function automatic logic op_known(logic [2:0] code);
        return code <= 3'd5;
    endfunction

    // Index of the final bit of an operation.
    function automatic logic [3:0] final_bit(op_e op);
        case (op)
            OP_WRITE: return 4'd8;
            OP_READ:  return 4'd7;
            default:  return 4'd0;
        endcase
    endfunction

    function automatic drive_t drive_of(op_e op, logic [1:0] q, logic [3:0] bitn,
                                        logic tx_msb, logic ack_bit);
        drive_t d;
        d.scl_rel = (q == 2'd1) || (q == 2'd2);
        d.sda_rel = 1'b1;
        d.chk     = 1'b0;
        case (op)
            OP_START, OP_RSTART: begin
                d.sda_rel = (q < 2'd2);
                d.chk     = (q == 2'd1);
            end
            OP_STOP: begin
                d.scl_rel = (q != 2'd0);
                d.sda_rel = (q >= 2'd2);
                d.chk     = (q == 2'd3);
            end
            OP_WRITE: begin
                d.sda_rel = (bitn < 4'd8) ? tx_msb : 1'b1;
                d.chk     = (q == 2'd2) && (bitn < 4'd8);
            end
            OP_ACK: begin
                d.sda_rel = ack_bit;
                d.chk     = (q == 2'd2);
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [DIVW-1:0] qdiv,
    output logic            tick
);
    logic [DIVW-1:0] cnt;

    assign tick = run && (cnt == qdiv);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + DIVW'(1);
    end
endmodule

// File: rtl/i2c_bus_mon.sv
module i2c_bus_mon (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic irq_en,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic start_seen,
    output logic stop_seen,
    output logic irq
);
    logic [1:0] scl_sy, sda_sy;
    logic       scl_p, sda_p;
    logic       scl_s;
    logic       start_det, stop_det;

    assign scl_s     = scl_sy[1];
    assign sda_s     = sda_sy[1];
    assign start_det = scl_s && scl_p && sda_p && !sda_s;
    assign stop_det  = scl_s && scl_p && !sda_p && sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sy <= 2'b11;
            sda_sy <= 2'b11;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[0], scl_in};
            sda_sy <= {sda_sy[0], sda_in};
            scl_p  <= scl_s;
            sda_p  <= sda_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
            irq        <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (start_det) begin
                start_seen <= 1'b1;
                stop_seen  <= 1'b0;
            end else if (stop_det) begin
                start_seen <= 1'b0;
                stop_seen  <= 1'b1;
                irq        <= irq_en && start_seen;
            end
        end
    end
endmodule

// File: rtl/i2c_op_seq.sv
module i2c_op_seq
    import i2c_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              ack_val,
    input  logic              clr_flags,
    input  logic              tick,
    input  logic              sda_s,
    input  logic              bus_busy,
    output logic              run,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_ack,
    output logic              done,
    output logic              wcol,
    output logic              bcol
);
    op_e               op_q;
    logic [1:0]        q;
    logic [3:0]        bitn;
    logic [BYTE_W-1:0] shreg;
    logic              ack_bit;
    drive_t            d;

    assign d = drive_of(op_q, q, bitn, shreg[BYTE_W-1], ack_bit);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            run     <= 1'b0;
            op_q    <= OP_START;
            q       <= 2'd0;
            bitn    <= 4'd0;
            shreg   <= '0;
            ack_bit <= 1'b1;
            scl_oe  <= 1'b0;
            sda_oe  <= 1'b0;
            done    <= 1'b0;
            wcol    <= 1'b0;
            bcol    <= 1'b0;
            if (rst) begin
                rx_data <= '0;
                rx_ack  <= 1'b1;
            end
        end else begin
            done <= 1'b0;
            if (clr_flags) begin
                wcol <= 1'b0;
                bcol <= 1'b0;
            end
            if (cmd_valid) begin
                if (run) begin
                    wcol <= 1'b1;
                end else if (op_known(cmd_op)) begin
                    if (op_e'(cmd_op) == OP_START && bus_busy) begin
                        bcol   <= 1'b1;
                        done   <= 1'b1;
                        scl_oe <= 1'b0;
                        sda_oe <= 1'b0;
                    end else begin
                        run     <= 1'b1;
                        op_q    <= op_e'(cmd_op);
                        q       <= 2'd0;
                        bitn    <= 4'd0;
                        shreg   <= tx_data;
                        ack_bit <= ack_val;
                    end
                end
            end
            if (run) begin
                scl_oe <= !d.scl_rel;
                sda_oe <= !d.sda_rel;
                if (tick) begin
                    if (d.chk && d.sda_rel && !sda_s) begin
                        run    <= 1'b0;
                        bcol   <= 1'b1;
                        done   <= 1'b1;
                        scl_oe <= 1'b0;
                        sda_oe <= 1'b0;
                    end else begin
                        if (q == 2'd2) begin
                            if (op_q == OP_READ)
                                rx_data <= {rx_data[BYTE_W-2:0], sda_s};
                            if (op_q == OP_WRITE && bitn == 4'd8)
                                rx_ack <= sda_s;
                        end
                        if (q == 2'd3) begin
                            if (bitn == final_bit(op_q)) begin
                                run  <= 1'b0;
                                done <= 1'b1;
                            end else begin
                                bitn <= bitn + 4'd1;
                                if (op_q == OP_WRITE)
                                    shreg <= {shreg[BYTE_W-2:0], 1'b0};
                            end
                        end
                        q <= q + 2'd1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master
    import i2c_arb_pkg::*;
#(
    parameter int DIVW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              master_sel,
    input  logic              irq_en,
    input  logic [DIVW-1:0]   qdiv,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              ack_val,
    input  logic              clr_flags,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_ack,
    output logic              wcol,
    output logic              bcol,
    output logic              start_seen,
    output logic              stop_seen,
    output logic              irq
);
    logic active, tick, sda_s, bus_busy;

    assign active   = en && master_sel;
    assign bus_busy = start_seen && !stop_seen;

    i2c_bus_mon u_mon (
        .clk(clk), .rst(rst), .active(active), .irq_en(irq_en),
        .scl_in(scl_in), .sda_in(sda_in), .sda_s(sda_s),
        .start_seen(start_seen), .stop_seen(stop_seen), .irq(irq)
    );

    i2c_qtick #(.DIVW(DIVW)) u_tick (
        .clk(clk), .rst(rst), .run(busy), .qdiv(qdiv), .tick(tick)
    );

    i2c_op_seq u_seq (
        .clk(clk), .rst(rst), .active(active),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .tx_data(tx_data),
        .ack_val(ack_val), .clr_flags(clr_flags), .tick(tick),
        .sda_s(sda_s), .bus_busy(bus_busy), .run(busy),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data),
        .rx_ack(rx_ack), .done(done), .wcol(wcol), .bcol(bcol)
    );
endmodule

// File: rtl/i2c_arb_master_chk.sv
module i2c_arb_master_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic master_sel,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic wcol,
    input logic bcol,
    input logic scl_oe,
    input logic sda_oe,
    input logic start_seen,
    input logic stop_seen,
    input logic irq
);
    a_r1_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r1_busy_from_cmd: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_valid));

    a_r2_busy_write_flags: assert property (@(posedge clk) disable iff (rst)
        (en && master_sel && busy && cmd_valid) |=> wcol);

    a_r3_collision_release: assert property (@(posedge clk) disable iff (rst)
        $rose(bcol) |-> (!scl_oe && !sda_oe && !busy));

    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(start_seen && stop_seen));

    a_r7_irq_on_stop: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stop_seen && !start_seen));

    a_r8_inactive_release: assert property (@(posedge clk) disable iff (rst)
        !(en && master_sel) |=> (!scl_oe && !sda_oe && !busy && !start_seen && !stop_seen));
endmodule

bind i2c_arb_master i2c_arb_master_chk u_chk (.*);

// File: tb/sim_i2c_arb_master.sv
module sim_i2c_arb_master;
    localparam int DIVW = 8;
    localparam logic [2:0] C_START = 3'd0, C_RSTART = 3'd1, C_WRITE = 3'd2,
                           C_READ = 3'd3, C_ACK = 3'd4, C_STOP = 3'd5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1, en = 1'b1, msel = 1'b1, irq_en = 1'b1;
    logic [DIVW-1:0] qdiv = 8'd3;
    logic cmd_valid = 1'b0, ack_val = 1'b0, clr = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] tx_data = 8'h00;
    logic ext_sda_low = 1'b0, ext_scl_low = 1'b0;
    logic scl_oe, sda_oe, busy, done, rx_ack, wcol, bcol, start_seen, stop_seen, irq;
    logic [7:0] rx_data;
    wire scl_line, sda_line;

    assign scl_line = !(scl_oe || ext_scl_low);
    assign sda_line = !(sda_oe || ext_sda_low);

    i2c_arb_master #(.DIVW(DIVW)) u0 (
        .clk(clk), .rst(rst), .en(en), .master_sel(msel), .irq_en(irq_en),
        .qdiv(qdiv), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .tx_data(tx_data),
        .ack_val(ack_val), .clr_flags(clr), .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
        .rx_data(rx_data), .rx_ack(rx_ack), .wcol(wcol), .bcol(bcol),
        .start_seen(start_seen), .stop_seen(stop_seen), .irq(irq)
    );

    int nchk = 0, nerr = 0, done_cnt = 0, irq_cnt = 0;
    always @(posedge clk) begin
        if (done) done_cnt++;
        if (irq)  irq_cnt++;
    end

    // Wire-level capture at every SCL rise
    logic [15:0] capt = 16'h0;
    time t_last = 0, t_prev = 0;
    always @(posedge scl_line) begin
        capt   = {capt[14:0], sda_line};
        t_prev = t_last;
        t_last = $time;
    end

    // Remote device model: presents a bit pattern, advancing at SCL falls
    logic [8:0] sl_pat = 9'h1FF;
    int sl_len = 0, sl_idx = 0;
    logic sl_act = 1'b0;
    always @(negedge scl_line) begin
        if (sl_act) begin
            sl_idx++;
            if (sl_idx < sl_len) ext_sda_low = !sl_pat[8-sl_idx];
            else begin ext_sda_low = 1'b0; sl_act = 1'b0; end
        end
    end

    function automatic time exp_period(input logic [DIVW-1:0] qd);
        return time'(4 * (int'(qd) + 1) * 20);
    endfunction

    function automatic logic [8:0] exp_wire(input logic [7:0] d, input logic a);
        return {d, a};
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [7:0] d, input logic a);
        @(negedge clk);
        cmd_op = op; tx_data = d; ack_val = a; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_op(input logic [2:0] op, input logic [7:0] d, input logic a,
                          output logic ok);
        int c0;
        c0 = done_cnt;
        send(op, d, a);
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (done_cnt != c0) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d, input logic a);
        logic ok;
        sl_pat = {8'hFF, a}; sl_len = 9; sl_idx = 0;
        ext_sda_low = 1'b0; sl_act = 1'b1;
        run_op(C_WRITE, d, 1'b0, ok);
        check("R1 write done", ok, 1'b1);
        check("R4 write bits on wire", capt[8:0], exp_wire(d, a));
        check("R4 rx_ack", rx_ack, a);
        check("R11 bit period", 32'(t_last - t_prev), 32'(exp_period(qdiv)));
        check("R3 no false collision on write", bcol, 1'b0);
    endtask

    task automatic do_read(input logic [7:0] b);
        logic ok;
        sl_pat = {b, 1'b1}; sl_len = 8; sl_idx = 0;
        ext_sda_low = !b[7]; sl_act = 1'b1;
        run_op(C_READ, 8'h00, 1'b0, ok);
        check("R9 read done", ok, 1'b1);
        check("R9 rx_data", rx_data, b);
        check("R9 no collision on read", bcol, 1'b0);
    endtask

    initial begin
        #(20 * 190000);
        nchk++; nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic ok;
        int c0;
        int seed;
        seed = int'($urandom(32'd20240611));
        idle(4);
        rst = 1'b0;
        idle(1);
        // R12 reset state
        check("R12 scl_oe", scl_oe, 1'b0);
        check("R12 sda_oe", sda_oe, 1'b0);
        check("R12 busy", busy, 1'b0);
        check("R12 flags", {wcol, bcol, start_seen, stop_seen}, 4'b0);

        // START from idle (both flags clear)
        run_op(C_START, 8'h00, 1'b0, ok);
        check("R6 start from idle done", ok, 1'b1);
        check("R5 start_seen after START", {start_seen, stop_seen}, 2'b10);
        check("R1 START holds wires low", {scl_oe, sda_oe}, 2'b11);

        do_write(8'hA6, 1'b0);
        do_write(8'h3B, 1'b1);
        do_read(8'h3C);

        run_op(C_ACK, 8'h00, 1'b0, ok);
        check("R10 ACK level 0", capt[0], 1'b0);
        run_op(C_ACK, 8'h00, 1'b1, ok);
        check("R10 NACK level 1", capt[0], 1'b1);

        // R2: second command while busy is dropped
        sl_pat = {8'hFF, 1'b0}; sl_len = 9; sl_idx = 0; ext_sda_low = 1'b0; sl_act = 1'b1;
        c0 = done_cnt;
        send(C_WRITE, 8'h5A, 1'b0);
        send(C_WRITE, 8'hFF, 1'b0);
        for (int i = 0; i < 4000 && done_cnt == c0; i++) @(negedge clk);
        idle(1);
        check("R2 wcol set", wcol, 1'b1);
        check("R2 dropped write left byte intact", capt[8:0], exp_wire(8'h5A, 1'b0));
        idle(20);
        check("R2 only one command completed", done_cnt - c0, 1);
        @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
        check("R2 wcol cleared", wcol, 1'b0);

        // R1: unused code ignored
        c0 = done_cnt;
        send(3'd6, 8'h00, 1'b0);
        idle(40);
        check("R1 code 6 no done", done_cnt - c0, 0);
        check("R1 code 6 not busy", busy, 1'b0);

        // STOP with event enabled
        c0 = irq_cnt;
        run_op(C_STOP, 8'h00, 1'b0, ok);
        idle(4);
        check("R5 stop_seen after STOP", {start_seen, stop_seen}, 2'b01);
        check("R7 irq on STOP", irq_cnt - c0, 1);
        check("R1 STOP releases wires", {scl_oe, sda_oe}, 2'b00);

        // Random transfers
        for (int it = 0; it < 12; it++) begin
            qdiv = DIVW'(3 + ($urandom % 4));
            run_op(C_START, 8'h00, 1'b0, ok);
            check("R6 start after stop", {ok, bcol}, 2'b10);
            for (int k = 0; k < 3; k++) begin
                if ($urandom % 2) do_write(8'($urandom), 1'($urandom));
                else              do_read(8'($urandom));
            end
            if (it % 3 == 0) begin
                run_op(C_RSTART, 8'h00, 1'b0, ok);
                check("R1 repeated start", {ok, bcol, start_seen}, 3'b101);
                do_write(8'($urandom), 1'b0);
            end
            run_op(C_STOP, 8'h00, 1'b0, ok);
            idle(4);
            check("R5 stop after random", stop_seen, 1'b1);
        end
        qdiv = 8'd3;

        // R3: arbitration lost in a data bit (0xA5 vs remote 0x85)
        run_op(C_START, 8'h00, 1'b0, ok);
        sl_pat = {8'h85, 1'b1}; sl_len = 8; sl_idx = 0; ext_sda_low = 1'b0; sl_act = 1'b1;
        run_op(C_WRITE, 8'hA5, 1'b0, ok);
        check("R3 data collision done", ok, 1'b1);
        check("R3 data collision bcol", bcol, 1'b1);
        check("R3 data collision release", {busy, scl_oe, sda_oe}, 3'b000);
        sl_act = 1'b0; ext_sda_low = 1'b0;
        idle(10);
        check("R3 bcol held", bcol, 1'b1);
        @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
        check("R3 bcol cleared", bcol, 1'b0);
        check("R5 remote release seen as STOP", stop_seen, 1'b1);

        // R3: arbitration lost during START (SDA held low without a START edge)
        ext_scl_low = 1'b1; idle(5);
        ext_sda_low = 1'b1; idle(5);
        ext_scl_low = 1'b0; idle(5);
        run_op(C_START, 8'h00, 1'b0, ok);
        check("R3 START collision bcol", {ok, bcol}, 2'b11);
        check("R3 START collision release", {scl_oe, sda_oe}, 2'b00);
        ext_sda_low = 1'b0; idle(10);
        @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;

        // R6: remote master owns the bus; START refused
        ext_sda_low = 1'b1; idle(10);
        check("R5 remote START seen", {start_seen, stop_seen}, 2'b10);
        run_op(C_START, 8'h00, 1'b0, ok);
        check("R6 refused START bcol", {ok, bcol}, 2'b11);
        check("R6 refused START no drive", {scl_oe, sda_oe, busy}, 3'b000);
        irq_en = 1'b0;
        c0 = irq_cnt;
        ext_sda_low = 1'b0; idle(10);
        check("R7 no irq when disabled", irq_cnt - c0, 0);
        irq_en = 1'b1;
        @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;

        // R8: disable clears flags and ignores commands
        run_op(C_START, 8'h00, 1'b0, ok);
        check("R8 start before disable", start_seen, 1'b1);
        en = 1'b0; idle(3);
        check("R8 disabled state", {start_seen, stop_seen, scl_oe, sda_oe}, 4'b0);
        c0 = done_cnt;
        send(C_START, 8'h00, 1'b0);
        idle(60);
        check("R8 command ignored while disabled", {done_cnt - c0, 32'(busy)}, 64'h0);
        en = 1'b1; msel = 1'b0;
        send(C_START, 8'h00, 1'b0);
        idle(60);
        check("R8 command ignored without master select", done_cnt - c0, 0);
        msel = 1'b1; idle(3);
        run_op(C_START, 8'h00, 1'b0, ok);
        check("R6 start with both flags clear", {ok, bcol, start_seen}, 3'b101);
        run_op(C_STOP, 8'h00, 1'b0, ok);
        idle(4);
        check("R5 final STOP", stop_seen, 1'b1);

        finish_run();
    end
endmodule